// File: doc/BRIEF.md
# Host Bus Half-Word Pairing Bridge

This block sits between an external host bus and a chip's 32-bit internal register and FIFO port. The host bus can be 32 or 16 bits wide. A strap input, sampled while reset is held, fixes the width until the next reset. In 32-bit mode each host access goes straight through to one internal access. In 16-bit mode the host moves one 32-bit word as two half-word accesses to the same word. The bridge joins those two halves into one internal access. It also flags access patterns that break the pairing rules.

The host side uses synchronous single-cycle strobes. An access is a cycle in which chip-select is high together with the read or the write strobe. The host address counts half-words, so bit 1 selects the half and the higher bits select the 32-bit word.

- **Writes in 16-bit mode:** the first half goes into a holding register. The internal write is issued once the matching second half arrives.
- **Reads in 16-bit mode:** the internal read happens on the first half. The other half is kept, so that both halves come from the same snapshot.
- **Rule violations:** the bridge drops the broken pairing and raises a one-cycle error pulse.

Top module: `hbus_dword_bridge`

## Requirements
- R1: The width strap is sampled on every clock edge while `rst` is high and held from then on. `cfg_status[2]` reads 1 for 32-bit mode and 0 for 16-bit mode, and every other bit of `cfg_status` is 0. Changes on the strap after reset have no effect.
- R2: In 32-bit mode, a write access gives `int_wr` high on the next cycle, with `int_waddr = host_addr[ADDR_W-1:2]` and `int_wdata` equal to the full `host_wdata`. A read access raises `int_rd` in the same cycle and returns `int_rdata` unchanged on `host_rdata`. `seq_err` never rises in this mode.
- R3: In 16-bit mode, two writes to the two halves of the same word can come in either order. `host_addr[1]` = 0 selects bits 15:0 and 1 selects bits 31:16, and the write data is taken from `host_wdata[15:0]`. Together they give exactly one `int_wr`, on the cycle after the second half, carrying the combined word. The first half produces no internal write.
- R4: In 16-bit mode, the first read of a pair raises `int_rd` and returns the selected half of `int_rdata` on `host_rdata[15:0]`. The following read of the other half of the same word raises no `int_rd`. It returns the other half of the word that was read on the first access.
- R5: In 16-bit mode, a second write to the same half as the pending one produces no internal write. `seq_err` pulses on the next cycle and the pending half is cleared, so the next write starts a new pair.
- R6: In 16-bit mode, a second read of the same half as the pending one returns 0 and raises no `int_rd`. `seq_err` pulses on the next cycle, and the next read starts a new pair with a fresh internal read.
- R7: In 16-bit mode, the pending half is abandoned if an access arrives with different word address bits (bit 2 and up) or the opposite direction. `seq_err` pulses on the next cycle, and the new access is treated as the first half of a new pair.
- R8: `host_oe_lo` is high exactly during a read access, meaning chip-select and the read strobe are high and the write strobe is low. `host_oe_hi` is the same but is never high in 16-bit mode. `host_rdata` is 0 outside read accesses, and its bits 31:16 are 0 in 16-bit mode. When both strobes are high, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is sampled while it is high |
| strap_wide | input | 1 | Width strap: 1 selects a 32-bit host bus, 0 selects a 16-bit host bus |
| host_addr | input | ADDR_W-1 | Host half-word address, bits ADDR_W-1 down to 1 |
| host_cs | input | 1 | Host chip-select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe, which wins over the read strobe |
| host_wdata | input | DATA_W | Host write data; only bits 15:0 are used in 16-bit mode |
| host_rdata | output | DATA_W | Host read data, valid during a read access |
| host_oe_lo | output | 1 | Output enable for the lower data lanes |
| host_oe_hi | output | 1 | Output enable for the upper data lanes |
| int_rd | output | 1 | Internal read strobe |
| int_raddr | output | ADDR_W-2 | Internal word address for reads |
| int_rdata | input | DATA_W | Internal read data, returned in the same cycle |
| int_wr | output | 1 | Internal write strobe (registered) |
| int_waddr | output | ADDR_W-2 | Internal word address for writes (registered) |
| int_wdata | output | DATA_W | Internal write data (registered) |
| seq_err | output | 1 | One-cycle pulse after a pairing rule violation |
| cfg_status | output | DATA_W | Status word with the latched width in bit 2 |

## Verification
The assertions check the following on every cycle:
- the latched width stays fixed after reset;
- no pairing state is ever pending in 32-bit mode;
- every internal write follows a host write access;
- an error pulse never coincides with an internal write;
- the upper-lane enable is never high in 16-bit mode.

The other behaviours can only be shown by the bench's scenarios. These are joining halves in both orders, returning the second read half from the first snapshot, and the three ways a pairing breaks: a repeated write, a repeated read, and a change of word address or direction. For each of them the bench's reference model predicts the exact data, strobe and error cycle.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  // classification of one host access with respect to the pending half
  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_FIRST  = 2'd1,
    ACC_SECOND = 2'd2,
    ACC_REPEAT = 2'd3
  } pair_kind_e;
endpackage

// File: rtl/hbus_pair_track.sv
module hbus_pair_track
  import hbus_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic             half,
  input  logic [IDX_W-1:0] idx,
  output pair_kind_e       kind,
  output logic             viol
);
  typedef struct packed {
    logic             valid;
    logic             is_wr;
    logic             half;
    logic [IDX_W-1:0] idx;
  } pend_t;

  pend_t pend_q;
  logic  access;
  logic  match;

  always_comb begin
    access = acc_wr | acc_rd;
    match  = pend_q.valid && (pend_q.idx == idx) && (pend_q.is_wr == acc_wr);
    kind   = ACC_NONE;
    if (access && !wide) begin
      if (match) kind = (half != pend_q.half) ? ACC_SECOND : ACC_REPEAT;
      else       kind = ACC_FIRST;
    end
    viol = (kind == ACC_REPEAT) || ((kind == ACC_FIRST) && pend_q.valid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      case (kind)
        ACC_FIRST:  pend_q <= '{valid: 1'b1, is_wr: acc_wr, half: half, idx: idx};
        ACC_SECOND,
        ACC_REPEAT: pend_q.valid <= 1'b0;
        default:    pend_q <= pend_q;
      endcase
    end
  end

  // R2: nothing is ever pending while the bus is 32 bits wide
  p_pend_idle_wide_r2: assert property (@(posedge clk) disable iff (rst)
    wide |-> !pend_q.valid)
    else $error("pending half in 32-bit mode");
endmodule

// File: rtl/hbus_wr_merge.sv
module hbus_wr_merge
  import hbus_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              acc_wr,
  input  pair_kind_e        kind,
  input  logic              half,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic              int_wr,
  output logic [IDX_W-1:0]  int_waddr,
  output logic [DATA_W-1:0] int_wdata
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_wr    <= 1'b0;
      int_waddr <= '0;
      int_wdata <= '0;
      hold_q    <= '0;
    end else begin
      int_wr <= 1'b0;
      if (acc_wr && wide) begin
        int_wr    <= 1'b1;
        int_waddr <= idx;
        int_wdata <= wdata;
      end else if (acc_wr && kind == ACC_FIRST) begin
        hold_q <= wdata[HALF_W-1:0];
      end else if (acc_wr && kind == ACC_SECOND) begin
        int_wr    <= 1'b1;
        int_waddr <= idx;
        int_wdata <= half ? {wdata[HALF_W-1:0], hold_q} : {hold_q, wdata[HALF_W-1:0]};
      end
    end
  end

  // R3: an internal write only ever follows a host write access
  p_wr_after_access_r3: assert property (@(posedge clk) disable iff (rst)
    int_wr |-> $past(acc_wr))
    else $error("internal write without host write");
endmodule

// File: rtl/hbus_rd_snap.sv
module hbus_rd_snap
  import hbus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              acc_rd,
  input  pair_kind_e        kind,
  input  logic              half,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              int_rd,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] snap_q;
  logic [HALF_W-1:0] lo_w;
  logic [HALF_W-1:0] hi_w;

  always_comb begin
    lo_w       = int_rdata[HALF_W-1:0];
    hi_w       = int_rdata[DATA_W-1:HALF_W];
    int_rd     = acc_rd && (wide || kind == ACC_FIRST);
    host_rdata = '0;
    if (acc_rd) begin
      if (wide) begin
        host_rdata = int_rdata;
      end else if (kind == ACC_FIRST) begin
        host_rdata[HALF_W-1:0] = half ? hi_w : lo_w;
      end else if (kind == ACC_SECOND) begin
        host_rdata[HALF_W-1:0] = snap_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
    end else if (acc_rd && !wide && kind == ACC_FIRST) begin
      snap_q <= half ? lo_w : hi_w;
    end
  end

  // R4: an internal read is only issued during a host read access
  p_rd_in_access_r4: assert property (@(posedge clk) disable iff (rst)
    int_rd |-> acc_rd)
    else $error("internal read outside host read");
endmodule

// File: rtl/hbus_dword_bridge.sv
module hbus_dword_bridge
  import hbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_wide,
  input  logic [ADDR_W-1:1] host_addr,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_oe_lo,
  output logic              host_oe_hi,
  output logic              int_rd,
  output logic [ADDR_W-3:0] int_raddr,
  input  logic [DATA_W-1:0] int_rdata,
  output logic              int_wr,
  output logic [ADDR_W-3:0] int_waddr,
  output logic [DATA_W-1:0] int_wdata,
  output logic              seq_err,
  output logic [DATA_W-1:0] cfg_status
);
  localparam int IDX_W = ADDR_W - 2;

  logic             wide_q;
  logic             acc_wr;
  logic             acc_rd;
  logic             half;
  logic [IDX_W-1:0] idx;
  pair_kind_e       kind;
  logic             viol;

  always_ff @(posedge clk) begin
    if (rst) wide_q <= strap_wide;
  end

  always_comb begin
    acc_wr     = host_cs & host_wr;
    acc_rd     = host_cs & host_rd & ~host_wr;
    half       = host_addr[1];
    idx        = host_addr[ADDR_W-1:2];
    host_oe_lo = acc_rd;
    host_oe_hi = acc_rd & wide_q;
    int_raddr  = idx;
    cfg_status = '0;
    cfg_status[2] = wide_q;
  end

  hbus_pair_track #(.IDX_W(IDX_W)) track_i (
    .clk(clk), .rst(rst), .wide(wide_q), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .half(half), .idx(idx), .kind(kind), .viol(viol)
  );

  hbus_wr_merge #(.IDX_W(IDX_W), .DATA_W(DATA_W)) wr_i (
    .clk(clk), .rst(rst), .wide(wide_q), .acc_wr(acc_wr), .kind(kind),
    .half(half), .idx(idx), .wdata(host_wdata),
    .int_wr(int_wr), .int_waddr(int_waddr), .int_wdata(int_wdata)
  );

  hbus_rd_snap #(.DATA_W(DATA_W)) rd_i (
    .clk(clk), .rst(rst), .wide(wide_q), .acc_rd(acc_rd), .kind(kind),
    .half(half), .int_rdata(int_rdata), .int_rd(int_rd), .host_rdata(host_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) seq_err <= 1'b0;
    else     seq_err <= viol;
  end

  // R1: the latched width never moves once reset is released
  p_width_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(wide_q))
    else $error("width changed after reset");

  // R5: a flagged violation never comes with an internal write
  p_no_wr_with_err_r5: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> !int_wr)
    else $error("internal write during error pulse");

  // R8: upper lanes are never driven on a 16-bit bus
  p_hi_lane_off_r8: assert property (@(posedge clk) disable iff (rst)
    !wide_q |-> !host_oe_hi)
    else $error("upper lanes driven in 16-bit mode");
endmodule

// File: tb/hbus_dword_bridge_tb.sv
module hbus_dword_bridge_tb_top;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strap_wide = 1'b1;
  logic [ADDR_W-1:1] host_addr = '0;
  logic              host_cs = 1'b0;
  logic              host_rd = 1'b0;
  logic              host_wr = 1'b0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              host_oe_lo;
  logic              host_oe_hi;
  logic              int_rd;
  logic [ADDR_W-3:0] int_raddr;
  logic [DATA_W-1:0] int_rdata;
  logic              int_wr;
  logic [ADDR_W-3:0] int_waddr;
  logic [DATA_W-1:0] int_wdata;
  logic              seq_err;
  logic [DATA_W-1:0] cfg_status;

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'h5A5AC3C3 ^ (i * 32'h00030011);
  endfunction

  assign int_rdata = pat(int'(int_raddr));

  hbus_dword_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .strap_wide(strap_wide), .host_addr(host_addr),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_oe_lo(host_oe_lo), .host_oe_hi(host_oe_hi),
    .int_rd(int_rd), .int_raddr(int_raddr), .int_rdata(int_rdata),
    .int_wr(int_wr), .int_waddr(int_waddr), .int_wdata(int_wdata),
    .seq_err(seq_err), .cfg_status(cfg_status)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // reference model state
  bit          m_wide;
  bit          pv, pwr, phalf;
  int          pidx;
  logic [15:0] m_hold, m_snap;
  bit          e_wr, e_err;
  int          e_waddr;
  logic [31:0] e_wdata;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // one host cycle: drive at negedge, compare 5 ns before posedge, advance model at posedge
  task automatic cyc(input bit cs, input bit rd, input bit wr, input int addr, input logic [31:0] wd);
    bit aw, ar, hf, first, second, rep, match;
    int ix;
    bit          x_rd;
    logic [31:0] x_rdata, full;
    @(negedge clk);
    host_cs = cs; host_rd = rd; host_wr = wr;
    host_addr = ADDR_W'(addr) >> 1; host_wdata = wd;
    aw = cs && wr; ar = cs && rd && !wr;
    hf = addr[1]; ix = (addr >> 2) & ((1 << (ADDR_W-2)) - 1);
    match  = pv && pidx == ix && pwr == aw;
    first  = !m_wide && (aw || ar) && !match;
    second = !m_wide && (aw || ar) && match && hf != phalf;
    rep    = !m_wide && (aw || ar) && match && hf == phalf;
    full = pat(ix);
    x_rd = 0; x_rdata = 0;
    if (ar) begin
      if (m_wide) begin x_rd = 1; x_rdata = full; end
      else if (first) begin x_rd = 1; x_rdata = {16'h0, hf ? full[31:16] : full[15:0]}; end
      else if (second) x_rdata = {16'h0, m_snap};
    end
    #5;
    chk("cfg_status", cfg_status, {29'h0, m_wide, 2'b00});
    chk("host_oe_lo", 32'(host_oe_lo), 32'(ar));
    chk("host_oe_hi", 32'(host_oe_hi), 32'(ar && m_wide));
    chk("int_rd", 32'(int_rd), 32'(x_rd));
    if (x_rd) chk("int_raddr", 32'(int_raddr), 32'(ix));
    chk("host_rdata", host_rdata, x_rdata);
    chk("int_wr", 32'(int_wr), 32'(e_wr));
    if (e_wr) begin
      chk("int_waddr", 32'(int_waddr), 32'(e_waddr));
      chk("int_wdata", int_wdata, e_wdata);
    end
    chk("seq_err", 32'(seq_err), 32'(e_err));
    @(posedge clk);
    e_wr = 0;
    e_err = (rep || (first && pv));
    if (aw && m_wide) begin e_wr = 1; e_waddr = ix; e_wdata = wd; end
    if (aw && first) m_hold = wd[15:0];
    if (aw && second) begin
      e_wr = 1; e_waddr = ix;
      e_wdata = hf ? {wd[15:0], m_hold} : {m_hold, wd[15:0]};
    end
    if (ar && first) m_snap = hf ? full[15:0] : full[31:16];
    if (first) begin pv = 1; pwr = aw; phalf = hf; pidx = ix; end
    else if (second || rep) pv = 0;
  endtask

  task automatic do_reset(input bit wide);
    strap_wide = wide;
    rst = 1'b1;
    host_cs = 0; host_rd = 0; host_wr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_wide = wide; pv = 0; e_wr = 0; e_err = 0; m_snap = 0; m_hold = 0;
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 32'h0);
  endtask

  initial begin
    // R1: reset state and strap latching, 32-bit
    cur_req = "R1";
    do_reset(1'b1);
    idle();
    strap_wide = 1'b0; // must be ignored after reset
    idle();
    // R2: direct 32-bit accesses
    cur_req = "R2";
    cyc(1, 0, 1, 8'h14, 32'hDEADBEEF);
    cyc(1, 1, 0, 8'h08, 32'h0);
    cyc(1, 1, 0, 8'h0A, 32'h0);
    cyc(1, 0, 1, 8'h16, 32'h12345678);
    idle();
    // R8: chip-select low, both strobes together
    cur_req = "R8";
    cyc(0, 1, 0, 8'h08, 32'h0);
    cyc(1, 1, 1, 8'h20, 32'hCAFEF00D);
    idle();

    // R1: 16-bit strap
    cur_req = "R1";
    do_reset(1'b0);
    idle();
    strap_wide = 1'b1;
    idle();
    // R3: write pairs, both orders
    cur_req = "R3";
    cyc(1, 0, 1, 8'h0C, 32'hFFFF1111);
    cyc(1, 0, 1, 8'h0E, 32'hEEEE2222);
    idle();
    cyc(1, 0, 1, 8'h16, 32'h00003333);
    idle();
    cyc(1, 0, 1, 8'h14, 32'h00004444);
    idle();
    // R4: read pairs, both orders
    cur_req = "R4";
    cyc(1, 1, 0, 8'h08, 32'h0);
    cyc(1, 1, 0, 8'h0A, 32'h0);
    cyc(1, 1, 0, 8'h1E, 32'h0);
    idle();
    cyc(1, 1, 0, 8'h1C, 32'h0);
    idle();
    // R8: upper lanes off, idle data zero, write wins
    cur_req = "R8";
    cyc(1, 1, 1, 8'h10, 32'h0000AAAA);
    cyc(1, 1, 1, 8'h12, 32'h0000BBBB);
    idle();
    // R5: repeated write half
    cur_req = "R5";
    cyc(1, 0, 1, 8'h24, 32'h00005555);
    cyc(1, 0, 1, 8'h24, 32'h00006666);
    cyc(1, 0, 1, 8'h26, 32'h00007777);
    cyc(1, 0, 1, 8'h24, 32'h00008888);
    idle();
    // R6: repeated read half
    cur_req = "R6";
    cyc(1, 1, 0, 8'h2A, 32'h0);
    cyc(1, 1, 0, 8'h2A, 32'h0);
    cyc(1, 1, 0, 8'h2A, 32'h0);
    cyc(1, 1, 0, 8'h28, 32'h0);
    idle();
    // R7: word address change and direction change
    cur_req = "R7";
    cyc(1, 1, 0, 8'h04, 32'h0);
    cyc(1, 1, 0, 8'h0A, 32'h0);
    cyc(1, 1, 0, 8'h08, 32'h0);
    cyc(1, 0, 1, 8'h30, 32'h00009999);
    cyc(1, 1, 0, 8'h32, 32'h0);
    cyc(1, 1, 0, 8'h30, 32'h0);
    cyc(1, 0, 1, 8'h40, 32'h0000ABCD);
    cyc(1, 0, 1, 8'h46, 32'h0000DCBA);
    cyc(1, 0, 1, 8'h44, 32'h00001234);
    idle();
    idle();

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule